// File: doc/BRIEF.md
# E1 Timeslot-Zero Overhead Bit Generator

This block produces the eight overhead bits that open every transmitted E1 frame (timeslot 0). A transmit timing source gives it a bit strobe, a frame-start marker and a multiframe-start marker. For each frame the block builds the eight-bit overhead word and shifts it out MSB first. An insert-enable output tells the downstream multiplexer which bit periods carry overhead.

Two host-written sources feed the word. The first is a pair of bytes refreshed once per double frame: one byte for the frame carrying the frame alignment signal (the align frame) and one for the other frame (the non-align frame). The second is a set of eight-bit arrays refreshed once per 16-frame multiframe, one bit per frame: Si for align frames, Si for non-align frames, the remote alarm bit, and Sa4 to Sa8. A seven-bit select input chooses, field by field, which of the two sources drives Si, the remote alarm bit and each Sa bit. Each source is captured into a shadow register only at its own boundary, so the host may rewrite it at any time during the period. Two sticky flags report each capture point, and the host clears them with write-one-to-clear pulses.

Top module: `e1_ts0_oh_tx`

## Requirements
- R1: While reset is held, and until the first frame start after it, `oh_bit`, `oh_ins`, `df_flag` and `mf_flag` are all 0.
- R2: A bit strobe that has `frame_sync` high starts a frame. For that strobe and the seven strobes after it, `oh_ins` is 1, and for later strobes it is 0. Both outputs change only on the clock edge of a bit strobe and hold their value between strobes.
- R3: In an align frame, overhead bits 2 to 8 are 0,0,1,1,0,1,1 in that order, whatever the host registers hold.
- R4: In a non-align frame, bit 2 is always 1. When the byte source is selected, bit 1 is byte bit 7, bit 3 (remote alarm) is byte bit 5, and bits 4 to 8 (Sa4 to Sa8) are byte bits 4 down to 0.
- R5: In an align frame with the byte source selected for Si, bit 1 is bit 7 of `host_af`.
- R6: `host_af`, `host_naf` and `host_sel` are captured on the frame-start strobe of each align frame. That capture serves both that align frame and the non-align frame after it, and writes made after the capture have no effect until the next one.
- R7: When a `host_sel` bit is 1 (bit 0 Si, bit 1 remote alarm, bits 2 to 6 Sa4 to Sa8), that field in the k-th frame of its type (align or non-align, k = 0 to 7 within the multiframe) takes bit 7-k of its multiframe array. Sa(4+j) is `host_sa_mf[8j+7:8j]`.
- R8: The multiframe arrays are captured on the frame-start strobe of the multiframe. Writes made after the capture have no effect until the next multiframe start.
- R9: `df_flag` becomes 1 after each align-frame start and stays 1 until a `df_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R10: `mf_flag` becomes 1 after each multiframe start and stays 1 until an `mf_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R11: A frame start with `mframe_sync` high is frame 0, an align frame. After it, frames alternate between non-align and align, counting modulo 16. A new `mframe_sync` realigns the count at any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per transmitted bit period |
| frame_sync | input | 1 | Marks the first bit of a frame; only counts together with `bit_en` |
| mframe_sync | input | 1 | Marks the first frame of a multiframe; only counts together with `frame_sync` |
| host_af | input | 8 | Align-frame overhead byte |
| host_naf | input | 8 | Non-align-frame overhead byte |
| host_si_af | input | 8 | Multiframe Si array for align frames |
| host_si_naf | input | 8 | Multiframe Si array for non-align frames |
| host_rai_mf | input | 8 | Multiframe remote alarm array |
| host_sa_mf | input | 40 | Multiframe Sa4..Sa8 arrays, Sa4 in the low byte |
| host_sel | input | 7 | Per-field source choice, 1 = multiframe array |
| df_clr | input | 1 | Write-one-to-clear pulse for `df_flag` |
| mf_clr | input | 1 | Write-one-to-clear pulse for `mf_flag` |
| oh_bit | output | 1 | Serial overhead bit |
| oh_ins | output | 1 | High while `oh_bit` carries overhead |
| df_flag | output | 1 | Sticky double-frame capture flag |
| mf_flag | output | 1 | Sticky multiframe capture flag |

## Verification
The case that needs care is a host clear pulse arriving in the same cycle that a capture boundary sets its flag. The bench provokes it by raising `df_clr` and `mf_clr` on the frame-start strobe of a multiframe-start frame. It judges the result by requiring both flags to read 1 afterwards, and a later clear pulse with no boundary must bring both back to 0. A second overlap, a host rewrite landing between a capture and its use, is covered by changing the registers between frames and predicting every shifted bit from a shadow model.

// File: rtl/e1_oh_pkg.sv
package e1_oh_pkg;

  localparam int OH_BITS   = 8;
  localparam int MF_FRAMES = 16;
  localparam int MF_WORD   = MF_FRAMES / 2;
  localparam int SA_NUM    = 5;
  localparam int SEL_W     = 2 + SA_NUM;
  localparam int IDX_W     = $clog2(MF_FRAMES);
  localparam int POS_W     = $clog2(MF_WORD);
  localparam int CNT_W     = $clog2(OH_BITS);

  localparam int SEL_SI  = 0;
  localparam int SEL_RAI = 1;
  localparam int SEL_SA0 = 2;

  localparam logic [OH_BITS-2:0] FAS_PATTERN = 7'b0011011;

  typedef struct packed {
    logic [OH_BITS-1:0] af;
    logic [OH_BITS-1:0] naf;
    logic [SEL_W-1:0]   sel;
  } df_src_t;

  typedef struct packed {
    logic [MF_WORD-1:0]        si_af;
    logic [MF_WORD-1:0]        si_naf;
    logic [MF_WORD-1:0]        rai;
    logic [SA_NUM*MF_WORD-1:0] sa;
  } mf_src_t;

endpackage

// File: rtl/e1_oh_timing.sv
module e1_oh_timing
  import e1_oh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_sync,
  input  logic             mframe_sync,
  output logic             fr_start,
  output logic             df_start,
  output logic             mf_start,
  output logic             frm_align,
  output logic [POS_W-1:0] frm_pos
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] cur_idx;

  always_comb begin
    cur_idx   = mframe_sync ? '0 : idx_q + 1'b1;
    fr_start  = bit_en & frame_sync;
    mf_start  = fr_start & mframe_sync;
    frm_align = ~cur_idx[0];
    df_start  = fr_start & frm_align;
    frm_pos   = cur_idx[IDX_W-1:1];
    idx_d     = fr_start ? cur_idx : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '1;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/e1_oh_builder.sv
module e1_oh_builder
  import e1_oh_pkg::*;
(
  input  logic               frm_align,
  input  logic [POS_W-1:0]   frm_pos,
  input  df_src_t            df,
  input  mf_src_t            mf,
  output logic [OH_BITS-1:0] frm_byte
);

  logic [POS_W-1:0]  mpos;
  logic [SA_NUM-1:0] sa_bit;
  logic              si_mf;
  logic              si_bit;
  logic              rai_bit;
  logic              unused_bits;

  assign mpos        = POS_W'(MF_WORD - 1) - frm_pos;
  assign unused_bits = ^{df.af[OH_BITS-2:0], df.naf[OH_BITS-2]};

  for (genvar j = 0; j < SA_NUM; j++) begin : g_sa
    logic [MF_WORD-1:0] word;
    assign word      = mf.sa[j*MF_WORD +: MF_WORD];
    assign sa_bit[j] = df.sel[SEL_SA0+j] ? word[mpos] : df.naf[SA_NUM-1-j];
  end

  always_comb begin
    si_mf   = frm_align ? mf.si_af[mpos] : mf.si_naf[mpos];
    si_bit  = df.sel[SEL_SI] ? si_mf
                             : (frm_align ? df.af[OH_BITS-1] : df.naf[OH_BITS-1]);
    rai_bit = df.sel[SEL_RAI] ? mf.rai[mpos] : df.naf[OH_BITS-3];
    if (frm_align) begin
      frm_byte = {si_bit, FAS_PATTERN};
    end else begin
      frm_byte            = '0;
      frm_byte[OH_BITS-1] = si_bit;
      frm_byte[OH_BITS-2] = 1'b1;
      frm_byte[OH_BITS-3] = rai_bit;
      for (int j = 0; j < SA_NUM; j++) begin
        frm_byte[SA_NUM-1-j] = sa_bit[j];
      end
    end
  end

endmodule

// File: rtl/e1_oh_serializer.sv
module e1_oh_serializer
  import e1_oh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fr_start,
  input  logic [OH_BITS-1:0] frm_byte,
  output logic               oh_bit,
  output logic               oh_ins
);

  logic [OH_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               bit_q, bit_d;
  logic               ins_q, ins_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    ins_d = ins_q;
    if (bit_en) begin
      if (fr_start) begin
        bit_d = frm_byte[OH_BITS-1];
        sh_d  = {frm_byte[OH_BITS-2:0], 1'b0};
        cnt_d = CNT_W'(OH_BITS - 1);
        ins_d = 1'b1;
      end else if (cnt_q != '0) begin
        bit_d = sh_q[OH_BITS-1];
        sh_d  = {sh_q[OH_BITS-2:0], 1'b0};
        cnt_d = cnt_q - 1'b1;
        ins_d = 1'b1;
      end else begin
        bit_d = 1'b0;
        ins_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
      ins_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      ins_q <= ins_d;
    end
  end

  assign oh_bit = bit_q;
  assign oh_ins = ins_q;

  AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(oh_ins) && $stable(oh_bit))); // R2
  AST_INS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fr_start) |=> oh_ins); // R2
  AST_INS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !fr_start && cnt_q == '0) |=> (!oh_ins && !oh_bit)); // R2

endmodule

// File: rtl/e1_oh_flags.sv
module e1_oh_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      flag_d = set[i] | (flag_q & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign flag[i] = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]); // R9, R10
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]); // R9, R10
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> $stable(flag[i])); // R9, R10
  end

endmodule

// File: rtl/e1_ts0_oh_tx.sv
module e1_ts0_oh_tx
  import e1_oh_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic                      frame_sync,
  input  logic                      mframe_sync,
  input  logic [OH_BITS-1:0]        host_af,
  input  logic [OH_BITS-1:0]        host_naf,
  input  logic [MF_WORD-1:0]        host_si_af,
  input  logic [MF_WORD-1:0]        host_si_naf,
  input  logic [MF_WORD-1:0]        host_rai_mf,
  input  logic [SA_NUM*MF_WORD-1:0] host_sa_mf,
  input  logic [SEL_W-1:0]          host_sel,
  input  logic                      df_clr,
  input  logic                      mf_clr,
  output logic                      oh_bit,
  output logic                      oh_ins,
  output logic                      df_flag,
  output logic                      mf_flag
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic             fr_start, df_start, mf_start, frm_align;
  logic [POS_W-1:0] frm_pos;

  e1_oh_timing u_timing (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .bit_en      (bit_en),
    .frame_sync  (frame_sync),
    .mframe_sync (mframe_sync),
    .fr_start    (fr_start),
    .df_start    (df_start),
    .mf_start    (mf_start),
    .frm_align   (frm_align),
    .frm_pos     (frm_pos)
  );

  df_src_t df_live, df_sh_q, df_sh_d;
  mf_src_t mf_live, mf_sh_q, mf_sh_d;

  always_comb begin
    df_live.af     = host_af;
    df_live.naf    = host_naf;
    df_live.sel    = host_sel;
    mf_live.si_af  = host_si_af;
    mf_live.si_naf = host_si_naf;
    mf_live.rai    = host_rai_mf;
    mf_live.sa     = host_sa_mf;
    df_sh_d        = df_start ? df_live : df_sh_q;
    mf_sh_d        = mf_start ? mf_live : mf_sh_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      df_sh_q <= '0;
      mf_sh_q <= '0;
    end else begin
      df_sh_q <= df_sh_d;
      mf_sh_q <= mf_sh_d;
    end
  end

  logic [OH_BITS-1:0] frm_byte;

  e1_oh_builder u_builder (
    .frm_align (frm_align),
    .frm_pos   (frm_pos),
    .df        (df_sh_d),
    .mf        (mf_sh_d),
    .frm_byte  (frm_byte)
  );

  e1_oh_serializer u_ser (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .bit_en   (bit_en),
    .fr_start (fr_start),
    .frm_byte (frm_byte),
    .oh_bit   (oh_bit),
    .oh_ins   (oh_ins)
  );

  logic [1:0] flag_vec;

  e1_oh_flags #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n_int),
    .set   ({mf_start, df_start}),
    .clr   ({mf_clr, df_clr}),
    .flag  (flag_vec)
  );

  assign df_flag = flag_vec[0];
  assign mf_flag = flag_vec[1];

  AST_MF_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n_int)
    mf_start |=> (df_flag && mf_flag && oh_ins)); // R11

endmodule

// File: tb/e1_ts0_oh_tx_tb.sv
module e1_ts0_oh_tx_tb;

  localparam int CLK_NS   = 10;
  localparam int FRM_BITS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, frame_sync, mframe_sync;
  logic [7:0]  host_af, host_naf, host_si_af, host_si_naf, host_rai_mf;
  logic [39:0] host_sa_mf;
  logic [6:0]  host_sel;
  logic        df_clr, mf_clr;
  logic        oh_bit, oh_ins, df_flag, mf_flag;

  always #(CLK_NS/2) clk = ~clk;

  e1_ts0_oh_tx u_dut (
    .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .frame_sync (frame_sync),
    .mframe_sync (mframe_sync), .host_af (host_af), .host_naf (host_naf),
    .host_si_af (host_si_af), .host_si_naf (host_si_naf),
    .host_rai_mf (host_rai_mf), .host_sa_mf (host_sa_mf), .host_sel (host_sel),
    .df_clr (df_clr), .mf_clr (mf_clr), .oh_bit (oh_bit), .oh_ins (oh_ins),
    .df_flag (df_flag), .mf_flag (mf_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  // independent model state
  int          m_idx = 15;
  logic [7:0]  m_af, m_naf, m_siaf, m_sinaf, m_rai;
  logic [39:0] m_sa;
  logic [6:0]  m_sel;

  function automatic logic [7:0] model_byte(input bit align, input int k);
    logic [7:0] b;
    int p;
    p = 7 - k;
    if (align) begin
      b[7]   = m_sel[0] ? m_siaf[p] : m_af[7];
      b[6:0] = 7'b0011011;
    end else begin
      b[7] = m_sel[0] ? m_sinaf[p] : m_naf[7];
      b[6] = 1'b1;
      b[5] = m_sel[1] ? m_rai[p] : m_naf[5];
      for (int j = 0; j < 5; j++)
        b[4-j] = m_sel[2+j] ? m_sa[8*j+p] : m_naf[4-j];
    end
    return b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: one frame of FRM_BITS strobes, each followed by an idle cycle
  task automatic run_frame(input bit mfs, input bit dclr, input bit mclr, input string tag);
    bit align;
    logic [7:0] b;
    string t;
    m_idx = mfs ? 0 : (m_idx + 1) % 16;
    align = (m_idx % 2 == 0);
    if (mfs) begin
      m_siaf = host_si_af; m_sinaf = host_si_naf; m_rai = host_rai_mf; m_sa = host_sa_mf;
    end
    if (align) begin
      m_af = host_af; m_naf = host_naf; m_sel = host_sel;
    end
    b = model_byte(align, m_idx / 2);
    t = align ? {"R3 R5 R11 ", tag} : {"R4 R11 ", tag};
    for (int i = 0; i < FRM_BITS; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      frame_sync  = (i == 0);
      mframe_sync = (i == 0) && mfs;
      df_clr = (i == 0) && dclr;
      mf_clr = (i == 0) && mclr;
      if (i < 8) begin
        exp_q.push_back({1'b1, b[7-i]});
        tag_q.push_back(t);
      end else begin
        exp_q.push_back(2'b00);
        tag_q.push_back("R2");
      end
      @(negedge clk);
      bit_en = 1'b0; frame_sync = 1'b0; mframe_sync = 1'b0;
      df_clr = 1'b0; mf_clr = 1'b0;
    end
  endtask

  task automatic pulse_clr(input bit d, input bit m);
    @(negedge clk);
    df_clr = d; mf_clr = m;
    @(negedge clk);
    df_clr = 1'b0; mf_clr = 1'b0;
  endtask

  // monitor: pops one expected item per bit strobe
  initial begin
    logic be;
    logic [1:0] e;
    string t;
    forever begin
      @(posedge clk);
      be = bit_en;
      @(negedge clk);
      if (be) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2: actual strobe with empty scoreboard expected none");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {6'd0, oh_ins, oh_bit}, {6'd0, e});
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bit_en = 0; frame_sync = 0; mframe_sync = 0; df_clr = 0; mf_clr = 0;
    host_af = 8'hFF; host_naf = 8'hB2; host_si_af = 0; host_si_naf = 0;
    host_rai_mf = 0; host_sa_mf = 0; host_sel = 7'h00;
    repeat (4) @(negedge clk);
    check("R1", {4'd0, oh_bit, oh_ins, df_flag, mf_flag}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {4'd0, oh_bit, oh_ins, df_flag, mf_flag}, 8'h00);

    // byte source, align register all ones: forced pattern must survive
    run_frame(1'b1, 1'b0, 1'b0, "R6");
    check("R9", {7'd0, df_flag}, 8'h01);
    check("R10", {7'd0, mf_flag}, 8'h01);
    pulse_clr(1'b1, 1'b0);
    check("R9", {7'd0, df_flag}, 8'h00);
    check("R10", {7'd0, mf_flag}, 8'h01);
    pulse_clr(1'b0, 1'b1);
    check("R10", {7'd0, mf_flag}, 8'h00);
    // rewrite after capture: next non-align frame keeps old byte (R6)
    host_naf = 8'h4D; host_af = 8'h00;
    run_frame(1'b0, 1'b0, 1'b0, "R6");
    check("R9", {7'd0, df_flag}, 8'h00);
    for (int f = 0; f < 14; f++) begin
      if (f % 3 == 1) host_naf = host_naf ^ 8'hA7;
      if (f % 4 == 2) host_af = ~host_af;
      run_frame(1'b0, 1'b0, 1'b0, "R6");
    end
    check("R10", {7'd0, mf_flag}, 8'h00);

    // multiframe source for every field
    host_sel = 7'h7F;
    host_si_af = 8'hA5; host_si_naf = 8'h3C; host_rai_mf = 8'hF0;
    host_sa_mf = 40'h81_6E_C3_19_5A;
    run_frame(1'b1, 1'b0, 1'b0, "R7 R8");
    for (int f = 1; f < 16; f++) begin
      if (f == 3) begin
        host_si_af = 8'h00; host_si_naf = 8'hFF; host_rai_mf = 8'h0F;
        host_sa_mf = ~host_sa_mf; host_naf = 8'hFF;
      end
      run_frame(1'b0, 1'b0, 1'b0, "R7 R8");
    end

    // mixed selection, then realignment mid-multiframe
    host_sel = 7'b1010110;
    host_si_af = 8'h6B; host_si_naf = 8'hD2; host_rai_mf = 8'h99;
    host_sa_mf = 40'h0F_E1_2D_B4_77; host_naf = 8'h35; host_af = 8'h80;
    run_frame(1'b1, 1'b0, 1'b0, "R7");
    for (int f = 1; f < 5; f++) run_frame(1'b0, 1'b0, 1'b0, "R7");
    run_frame(1'b1, 1'b0, 1'b0, "R7 R11");
    for (int f = 1; f < 7; f++) run_frame(1'b0, 1'b0, 1'b0, "R7 R11");

    // set and clear in the same cycle: set wins
    pulse_clr(1'b1, 1'b1);
    check("R9", {7'd0, df_flag}, 8'h00);
    check("R10", {7'd0, mf_flag}, 8'h00);
    run_frame(1'b1, 1'b1, 1'b1, "R9 R10");
    check("R9", {7'd0, df_flag}, 8'h01);
    check("R10", {7'd0, mf_flag}, 8'h01);
    pulse_clr(1'b1, 1'b1);
    check("R9", {7'd0, df_flag}, 8'h00);
    check("R10", {7'd0, mf_flag}, 8'h00);

    repeat (3) @(negedge clk);
    check("R2", 8'(exp_q.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule